// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns virtual addresses from instruction fetch and load/store traffic into physical addresses. Each address is split into a page number in the upper bits and an in-page offset in the lower bits. The page number indexes a single-level page table, and that table belongs to the process that is currently running. The offset passes through unchanged. Each lookup also checks the entry's access rights against the kind of access. A lookup ends in one of two ways: it returns a physical address, or it returns a fault code that tells a missing page apart from a rights violation.

The unit holds one page table per process in internal storage. A table-select register names the running process, and writing that register switches the whole address space in one step. Two processes can therefore map the same virtual address to different physical pages. Software fills the tables through a write port that carries the process, the virtual page, a valid bit, a rights code and the physical page. With the default parameters the page size is 1 KB, there are 32 virtual pages (a 15-bit virtual address), 8 physical pages (a 13-bit physical address) and 4 processes.

Top module: `pt_xlate_unit`

## Requirements
- R1: On a successful lookup, the low 10 bits of the physical address equal the low 10 bits of the virtual address.
- R2: On success, the physical page number (physical address bits 12..10) is the entry indexed by the selected process and the virtual page number (virtual address bits 14..10), so the result is {ppn, offset}.
- R3: While reset is asserted and after it ends, rsp_valid_o, rsp_fault_o and rsp_pa_o are 0. Reset clears every valid bit and sets the table select to process 0, so a lookup before any table write returns a page fault.
- R4: A lookup that hits an entry whose valid bit is 0 returns fault code 01 (page fault) with a physical address of 0.
- R5: Rights codes are 00 read-only, 01 read/write, 10 execute-only and 11 read/write/execute. A load is allowed for every code except 10. A store is allowed only for 01 and 11. A fetch is allowed only for 10 and 11. A denied access returns fault code 10 (protection fault) with a physical address of 0.
- R6: An entry that is not valid always returns a page fault, whatever rights code it holds.
- R7: A write to the table-select register with value p makes later lookups use the table of process p. The same virtual address gives different physical addresses in different processes.
- R8: The result of a lookup appears on the edge after req_i is sampled, with rsp_valid_o high for exactly that one cycle per request. Back-to-back requests give back-to-back results.
- R9: When a table write and a lookup hit the same entry in the same cycle, the lookup returns the old entry contents. The next lookup sees the new contents.
- R10: When rsp_valid_o is low, rsp_fault_o and rsp_pa_o are 0. Fault code 11 is never produced.
- R11: Access type encoding: 00 load, 01 store, 10 instruction fetch. Code 11 is treated as a load.
- R12: When the table-select register is written in the same cycle as a lookup, that lookup uses the previous selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Write strobe for the table-select register |
| sel_i | input | 2 | New process select value |
| wr_en_i | input | 1 | Page table entry write strobe |
| wr_pid_i | input | 2 | Process whose table is written |
| wr_vpn_i | input | 5 | Virtual page number of the written entry |
| wr_valid_i | input | 1 | Valid bit of the written entry |
| wr_rights_i | input | 2 | Rights code of the written entry |
| wr_ppn_i | input | 3 | Physical page number of the written entry |
| req_i | input | 1 | Lookup request |
| req_acc_i | input | 2 | Access type of the lookup |
| req_va_i | input | 15 | Virtual address |
| rsp_valid_o | output | 1 | Lookup result strobe |
| rsp_fault_o | output | 2 | Fault code: 00 none, 01 page, 10 protection |
| rsp_pa_o | output | 13 | Physical address, 0 on a fault |

## Verification
The assertions check the following on every cycle: the one-cycle request-to-result timing, the offset passthrough on success, a zero address on every fault, quiet outputs while no result is present, and the absence of the illegal fault code. Only the bench's scenarios can show the rest, because each depends on the history of table contents. Those behaviours are the correct page number for a given process and entry, each rights code against each access type, a page fault taking priority over a rights violation, address-space switching, and the old-contents result when a write and a lookup collide.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RGT_RO  = 2'b00,
    RGT_RW  = 2'b01,
    RGT_XO  = 2'b10,
    RGT_RWX = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

endpackage

// File: rtl/pt_table_store.sv
module pt_table_store #(
  parameter int NPROC = 4,
  parameter int VPN_W = 5,
  parameter int PPN_W = 3,
  localparam int PID_W = $clog2(NPROC),
  localparam int PAGES = 1 << VPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PID_W-1:0] wpid_i,
  input  logic [VPN_W-1:0] wvpn_i,
  input  logic             wvalid_i,
  input  logic [1:0]       wrights_i,
  input  logic [PPN_W-1:0] wppn_i,
  input  logic [PID_W-1:0] rpid_i,
  input  logic [VPN_W-1:0] rvpn_i,
  output logic             rvalid_o,
  output logic [1:0]       rrights_o,
  output logic [PPN_W-1:0] rppn_o
);

  logic             bank_v   [NPROC];
  logic [1:0]       bank_r   [NPROC];
  logic [PPN_W-1:0] bank_ppn [NPROC];

  // one bank per process; read is combinational so a colliding write lands after the read
  for (genvar p = 0; p < NPROC; p++) begin : g_bank
    logic [PAGES-1:0] valid_q;
    logic [1:0]       rights_q [PAGES];
    logic [PPN_W-1:0] ppn_q    [PAGES];
    logic             hit_w;

    assign hit_w = we_i && (wpid_i == PID_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q <= '0;
      else if (hit_w) valid_q[wvpn_i] <= wvalid_i;
    end

    always_ff @(posedge clk_i) begin
      if (hit_w) begin
        rights_q[wvpn_i] <= wrights_i;
        ppn_q[wvpn_i]    <= wppn_i;
      end
    end

    assign bank_v[p]   = valid_q[rvpn_i];
    assign bank_r[p]   = rights_q[rvpn_i];
    assign bank_ppn[p] = ppn_q[rvpn_i];
  end

  assign rvalid_o  = bank_v[rpid_i];
  assign rrights_o = bank_r[rpid_i];
  assign rppn_o    = bank_ppn[rpid_i];

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_xlate_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic [1:0] rights_i,
  output logic       ok_o
);

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_STORE: ok_o = (rights_i == RGT_RW) || (rights_i == RGT_RWX);
      ACC_FETCH: ok_o = rights_i[1];
      default:   ok_o = (rights_i != RGT_XO);
    endcase
  end

endmodule

// File: rtl/pt_xlate_unit.sv
module pt_xlate_unit
  import pt_xlate_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int OFF_W = 10,
  parameter int VA_W  = 15,
  parameter int PA_W  = 13,
  localparam int PID_W = $clog2(NPROC),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [PID_W-1:0] sel_i,
  input  logic             wr_en_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic             wr_valid_i,
  input  logic [1:0]       wr_rights_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             req_i,
  input  logic [1:0]       req_acc_i,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_fault_o,
  output logic [PA_W-1:0]  rsp_pa_o
);

  logic [PID_W-1:0] sel_q;
  logic             ent_valid;
  logic [1:0]       ent_rights;
  logic [PPN_W-1:0] ent_ppn;
  logic             perm_ok;
  fault_e           fault_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_we_i) sel_q <= sel_i;
  end

  pt_table_store #(.NPROC(NPROC), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i),
    .wpid_i    (wr_pid_i),
    .wvpn_i    (wr_vpn_i),
    .wvalid_i  (wr_valid_i),
    .wrights_i (wr_rights_i),
    .wppn_i    (wr_ppn_i),
    .rpid_i    (sel_q),
    .rvpn_i    (req_va_i[VA_W-1:OFF_W]),
    .rvalid_o  (ent_valid),
    .rrights_o (ent_rights),
    .rppn_o    (ent_ppn)
  );

  pt_perm_check u_perm (
    .acc_i    (req_acc_i),
    .rights_i (ent_rights),
    .ok_o     (perm_ok)
  );

  // page fault outranks protection fault
  always_comb begin
    if (!ent_valid)    fault_d = FLT_PAGE;
    else if (!perm_ok) fault_d = FLT_PROT;
    else               fault_d = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= FLT_NONE;
      rsp_pa_o    <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rsp_fault_o <= req_i ? fault_d : FLT_NONE;
      rsp_pa_o    <= (req_i && fault_d == FLT_NONE) ?
                     {ent_ppn, req_va_i[OFF_W-1:0]} : '0;
    end
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_offset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |->
      rsp_pa_o[OFF_W-1:0] == $past(req_va_i[OFF_W-1:0]));
  p_fault_pa_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o != FLT_NONE) |-> rsp_pa_o == '0);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_fault_o == FLT_NONE && rsp_pa_o == '0));
  p_legal_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != 2'b11);

endmodule

// File: tb/sim_pt_xlate_unit.sv
module sim_pt_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic [1:0]  sel = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_pid = '0;
  logic [4:0]  wr_vpn = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_rights = '0;
  logic [2:0]  wr_ppn = '0;
  logic        req = 1'b0;
  logic [1:0]  req_acc = '0;
  logic [14:0] req_va = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [12:0] rsp_pa;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  logic req_seen = 1'b0;

  logic [14:0] exp_q[$];
  string       tag_q[$];

  logic       m_valid  [4][32];
  logic [1:0] m_rights [4][32];
  logic [2:0] m_ppn    [4][32];
  logic [1:0] m_sel;

  always #10 clk = ~clk;

  pt_xlate_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_we_i(sel_we), .sel_i(sel),
    .wr_en_i(wr_en), .wr_pid_i(wr_pid), .wr_vpn_i(wr_vpn),
    .wr_valid_i(wr_valid), .wr_rights_i(wr_rights), .wr_ppn_i(wr_ppn),
    .req_i(req), .req_acc_i(req_acc), .req_va_i(req_va),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_pa_o(rsp_pa)
  );

  // reference: {fault, pa}
  function automatic logic [14:0] model(logic [14:0] va, logic [1:0] acc);
    logic [4:0] vpn = va[14:10];
    logic [1:0] r;
    bit ok;
    if (!m_valid[m_sel][vpn]) return {2'b01, 13'h0};
    r = m_rights[m_sel][vpn];
    case (acc)
      2'b01:   ok = (r == 2'b01) || (r == 2'b11);
      2'b10:   ok = (r == 2'b10) || (r == 2'b11);
      default: ok = (r != 2'b10);
    endcase
    if (!ok) return {2'b10, 13'h0};
    return {2'b00, m_ppn[m_sel][vpn], va[9:0]};
  endfunction

  task automatic fail(string tag, logic [14:0] got, logic [14:0] exp);
    n_errors++;
    $display("FAIL %s: got fault=%b pa=%h expected fault=%b pa=%h",
             tag, got[14:13], got[12:0], exp[14:13], exp[12:0]);
  endtask

  // one cycle of stimulus, called at a negedge, returns at the next negedge
  task automatic cyc(bit lk, logic [14:0] va, logic [1:0] acc,
                     bit we, logic [1:0] pid, logic [4:0] vpn, bit v,
                     logic [1:0] r, logic [2:0] p,
                     bit swe, logic [1:0] s, string tag);
    if (lk) begin
      exp_q.push_back(model(va, acc));
      tag_q.push_back(tag);
    end
    req = lk; req_va = va; req_acc = acc;
    wr_en = we; wr_pid = pid; wr_vpn = vpn; wr_valid = v; wr_rights = r; wr_ppn = p;
    sel_we = swe; sel = s;
    @(posedge clk);
    if (we) begin
      m_valid[pid][vpn] = v; m_rights[pid][vpn] = r; m_ppn[pid][vpn] = p;
    end
    if (swe) m_sel = s;
    @(negedge clk);
    req = 1'b0; wr_en = 1'b0; sel_we = 1'b0;
  endtask

  task automatic look(logic [14:0] va, logic [1:0] acc, string tag);
    cyc(1, va, acc, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic put(logic [1:0] pid, logic [4:0] vpn, bit v, logic [1:0] r, logic [2:0] p);
    cyc(0, 0, 0, 1, pid, vpn, v, r, p, 0, 0, "");
  endtask

  task automatic pick(logic [1:0] s);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, "");
  endtask

  always @(posedge clk) req_seen <= req;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid !== req_seen) begin
        n_checks++;
        n_errors++;
        $display("FAIL R8: rsp_valid=%b expected %b", rsp_valid, req_seen);
      end
      if (rsp_valid) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_errors++;
          $display("FAIL R8: result with no pending request, got %b/%h expected none",
                   rsp_fault, rsp_pa);
        end else begin
          logic [14:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({rsp_fault, rsp_pa} !== e) fail(t, {rsp_fault, rsp_pa}, e);
        end
      end else if (rsp_fault !== 2'b00 || rsp_pa !== '0) begin
        n_checks++;
        fail("R10", {rsp_fault, rsp_pa}, 15'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 32; v++) begin
        m_valid[p][v] = 1'b0; m_rights[p][v] = '0; m_ppn[p][v] = '0;
      end
    m_sel = '0;
    repeat (2) @(negedge clk);
    n_checks++;  // R3: outputs quiet in reset
    if (rsp_valid !== 1'b0 || rsp_fault !== 2'b00 || rsp_pa !== '0)
      fail("R3", {rsp_fault, rsp_pa}, 15'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: all entries invalid after reset
    look(15'h0C21, 2'b00, "R3");
    look(15'h7FFF, 2'b10, "R3");

    // read/write page: vpn3 -> ppn5 (R1, R2, R5)
    put(0, 3, 1, 2'b01, 3'd5);
    look({5'd3, 10'h2A5}, 2'b00, "R2");
    look({5'd3, 10'h3FF}, 2'b01, "R1");
    look({5'd3, 10'h000}, 2'b10, "R5");

    // read-only page: vpn4 -> ppn2
    put(0, 4, 1, 2'b00, 3'd2);
    look({5'd4, 10'h155}, 2'b00, "R5");
    look({5'd4, 10'h155}, 2'b01, "R5");
    look({5'd4, 10'h155}, 2'b10, "R5");

    // execute-only page: vpn5 -> ppn7, type 11 acts as load (R11)
    put(0, 5, 1, 2'b10, 3'd7);
    look({5'd5, 10'h001}, 2'b10, "R11");
    look({5'd5, 10'h001}, 2'b00, "R5");
    look({5'd5, 10'h001}, 2'b11, "R11");
    look({5'd5, 10'h001}, 2'b01, "R5");

    // rwx page with top vpn and ppn 0, back-to-back (R8)
    put(0, 31, 1, 2'b11, 3'd0);
    look(15'h7FFF, 2'b00, "R8");
    look(15'h7C00, 2'b01, "R8");
    look(15'h7E3C, 2'b10, "R8");

    // invalid entry with restrictive rights: page fault wins (R6, R4)
    put(0, 7, 0, 2'b00, 3'd6);
    look({5'd7, 10'h0F0}, 2'b01, "R6");
    look({5'd7, 10'h0F0}, 2'b10, "R4");
    // invalidate a previously valid entry
    put(0, 4, 0, 2'b11, 3'd2);
    look({5'd4, 10'h010}, 2'b00, "R4");

    // per-process tables (R7)
    put(1, 3, 1, 2'b01, 3'd1);
    put(2, 3, 1, 2'b11, 3'd4);
    look({5'd3, 10'h123}, 2'b00, "R7");
    pick(1);
    look({5'd3, 10'h123}, 2'b00, "R7");
    look({5'd5, 10'h123}, 2'b10, "R7");
    pick(2);
    look({5'd3, 10'h123}, 2'b10, "R7");

    // select written with a lookup: lookup uses old select (R12)
    cyc(1, {5'd3, 10'h044}, 2'b00, 0, 0, 0, 0, 0, 0, 1, 2'd0, "R12");
    look({5'd3, 10'h044}, 2'b00, "R12");

    // write and lookup collide on the same entry (R9)
    cyc(1, {5'd3, 10'h200}, 2'b01, 1, 0, 3, 1, 2'b00, 3'd6, 0, 0, "R9");
    look({5'd3, 10'h200}, 2'b01, "R9");
    look({5'd3, 10'h200}, 2'b00, "R9");

    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule